// File: doc/BRIEF.md
# Shared-Memory Ring Queue Producer

This block is a bus-master engine that feeds a single-producer, single-consumer ring queue. The ring lives entirely in a shared memory region that the engine reaches through a simple request/response port. The region opens with a four-word header. Word 0 is the read index, which only the consumer writes. Word 1 is the write index, which only this engine writes. Word 2 holds the slot count, and word 3 is spare. The data slots follow the header, one 32-bit word per slot.

Words arrive on a valid/ready stream. For each word the engine stores the word into the slot named by its private write index. Once that store has been acknowledged, it publishes the advanced write index. It never learns the consumer's progress through a flag. Instead it keeps a cached copy of the read index, and it re-reads word 0 only when that cached copy says the ring is full. If the fresh value still shows a full ring, the engine waits a programmable number of cycles and reads word 0 again, so no data is ever dropped. A start pulse runs a one-time setup that clears both indices and records the slot count. This setup must run before any traffic.

Top module: `ringq_producer`

## Requirements
- R1: After reset, `s_ready`, `mem_req_valid` and `busy` are low. No memory request is made and no input word is taken until `start` is pulsed, even while `s_valid` is high.
- R2: On `start`, the engine issues three writes in this order, each waiting for its response: 0 to base+0 (read index), 0 to base+4 (write index), then CAPACITY to base+8.
- R3: Each accepted word is written to byte address base + (4 + t) × 4, where t is the current write index (0 to CAPACITY−1).
- R4: The write-index update to base+4 is issued only after the slot write's response has arrived. It carries (t + 1) mod CAPACITY.
- R5: The ring is full when (t + 1) mod CAPACITY equals the read index. The engine never publishes a write index equal to the read index, so at most CAPACITY−1 words are unread.
- R6: Only base+0 is ever read. After a read that finds the ring full, the next read of base+0 is issued no earlier than `poll_interval` + 1 cycles after that read's response.
- R7: Words reach the ring in the order they were accepted, with none lost and none duplicated.
- R8: `busy` goes high in the cycle after a `start` that is taken. It is low whenever the engine is waiting for input with no request outstanding.
- R9: At most one memory request is outstanding. While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address stay unchanged.
- R10: `s_ready` is high only while the engine is waiting for input. After a word is taken, no further word is taken until that word's write-index update has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that runs the one-time header setup |
| poll_interval | input | POLL_W (16) | Cycles to wait between reads of a full ring's read index |
| s_valid | input | 1 | Input word valid |
| s_data | input | DATA_W (32) | Input word |
| s_ready | output | 1 | Engine can take a word |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W (32) | Byte address |
| mem_req_wdata | output | DATA_W (32) | Write data |
| mem_rsp_valid | input | 1 | One response per accepted request, at least one cycle after acceptance |
| mem_rsp_rdata | input | DATA_W (32) | Read data, valid with a read response |
| busy | output | 1 | Engine is setting up or handling a word |

## Verification
The hazardous coincidence is the consumer advancing the read index in memory in the same cycle that the engine's read of that index is answered. A second one is a new word being offered while the engine is still polling a full ring. The bench provokes both with a consumer that is held off for hundreds of cycles at first and later switches on and off at random, while the memory grants requests at random and answers after a fixed latency. Each result is judged at the memory: every published write index is checked against the read index held there at that moment. Every word the consumer drains is compared with the order in which words were taken, and every poll gap after a full read is measured against `poll_interval`.

// File: rtl/ringq_pkg.sv
package ringq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_INIT_HEAD,
    ST_INIT_TAIL,
    ST_INIT_CAP,
    ST_READY,
    ST_READ_HEAD,
    ST_POLL_WAIT,
    ST_WRITE_SLOT,
    ST_WRITE_TAIL
  } rq_state_e;

  // header word indices; the slot layout depends on their count
  localparam int HDR_HEAD  = 0;
  localparam int HDR_TAIL  = 1;
  localparam int HDR_CAP   = 2;
  localparam int HDR_WORDS = 4;
  localparam int WORD_BYTES = 4;

endpackage

// File: rtl/ringq_poll_timer.sv
module ringq_poll_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_n  = cnt_q;
    if (load)               cnt_n = load_val;
    else if (cnt_q != '0)   cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign expired = (cnt_q == '0);

  // R6: the wait window shrinks by exactly one per cycle
  p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ringq_ptrs.sv
module ringq_ptrs #(
  parameter int CAPACITY = 8,
  parameter int IDX_W    = $clog2(CAPACITY)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             head_load,
  input  logic [IDX_W-1:0] head_val,
  input  logic             tail_adv,
  output logic [IDX_W-1:0] tail,
  output logic [IDX_W-1:0] tail_next,
  output logic             full
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(CAPACITY - 1);

  logic [IDX_W-1:0] tail_q, tail_n, head_q, head_n;

  generate
    if ((CAPACITY & (CAPACITY - 1)) == 0) begin : g_pow2
      assign tail_next = tail_q + 1'b1;
    end else begin : g_mod
      assign tail_next = (tail_q == LAST) ? '0 : tail_q + 1'b1;
    end
  endgenerate

  always_comb begin
    tail_n = tail_q;
    head_n = head_q;
    if (clr) begin
      tail_n = '0;
      head_n = '0;
    end else begin
      if (tail_adv)  tail_n = tail_next;
      if (head_load) head_n = head_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q <= '0;
      head_q <= '0;
    end else begin
      if (clr || tail_adv)  tail_q <= tail_n;
      if (clr || head_load) head_q <= head_n;
    end
  end

  assign tail = tail_q;
  assign full = (tail_next == head_q);

  // R4: the private write index stays inside the ring
  p_tail_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tail_q) < CAPACITY));

  // R5: the write index is never advanced onto the known read index
  p_no_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tail_adv |-> !full);

endmodule

// File: rtl/ringq_addr.sv
module ringq_addr
  import ringq_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h1000,
  parameter int                IDX_W     = 3
) (
  input  rq_state_e         state,
  input  logic [IDX_W-1:0]  tail,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] HEAD_A = BASE_ADDR + ADDR_W'(HDR_HEAD * WORD_BYTES);
  localparam logic [ADDR_W-1:0] TAIL_A = BASE_ADDR + ADDR_W'(HDR_TAIL * WORD_BYTES);
  localparam logic [ADDR_W-1:0] CAP_A  = BASE_ADDR + ADDR_W'(HDR_CAP * WORD_BYTES);
  localparam logic [ADDR_W-1:0] SLOT_A = BASE_ADDR + ADDR_W'(HDR_WORDS * WORD_BYTES);

  logic [ADDR_W-1:0] slot_off;
  assign slot_off = ADDR_W'({tail, 2'b00});

  always_comb begin
    unique case (state)
      ST_INIT_TAIL, ST_WRITE_TAIL: addr = TAIL_A;
      ST_INIT_CAP:                 addr = CAP_A;
      ST_WRITE_SLOT:               addr = SLOT_A + slot_off;
      default:                     addr = HEAD_A;
    endcase
  end

endmodule

// File: rtl/ringq_producer.sv
module ringq_producer
  import ringq_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h1000,
  parameter int                CAPACITY  = 8,
  parameter int                POLL_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [POLL_W-1:0] poll_interval,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic              busy
);

  localparam int IDX_W = $clog2(CAPACITY);

  rq_state_e         state_q, state_n;
  logic              sent_q, sent_n;
  logic [DATA_W-1:0] data_q;
  logic              op_active, rsp_done, take_word;
  logic              clr_ptrs, head_load, tail_adv, timer_load, timer_exp;
  logic              ring_full, fresh_full;
  logic [IDX_W-1:0]  tail, tail_next;

  ringq_ptrs #(.CAPACITY(CAPACITY), .IDX_W(IDX_W)) u_ptrs (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr_ptrs),
    .head_load (head_load),
    .head_val  (mem_rsp_rdata[IDX_W-1:0]),
    .tail_adv  (tail_adv),
    .tail      (tail),
    .tail_next (tail_next),
    .full      (ring_full)
  );

  ringq_poll_timer #(.CNT_W(POLL_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (poll_interval),
    .expired  (timer_exp)
  );

  ringq_addr #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .IDX_W(IDX_W)) u_addr (
    .state (state_q),
    .tail  (tail),
    .addr  (mem_req_addr)
  );

  always_comb begin
    op_active = (state_q == ST_INIT_HEAD) || (state_q == ST_INIT_TAIL) ||
                (state_q == ST_INIT_CAP)  || (state_q == ST_READ_HEAD) ||
                (state_q == ST_WRITE_SLOT) || (state_q == ST_WRITE_TAIL);
    mem_req_valid = op_active && !sent_q;
    mem_req_write = (state_q != ST_READ_HEAD);
    unique case (state_q)
      ST_INIT_CAP:   mem_req_wdata = DATA_W'(CAPACITY);
      ST_WRITE_SLOT: mem_req_wdata = data_q;
      ST_WRITE_TAIL: mem_req_wdata = DATA_W'(tail_next);
      default:       mem_req_wdata = '0;
    endcase
    s_ready   = (state_q == ST_READY);
    busy      = (state_q != ST_IDLE) && (state_q != ST_READY);
    rsp_done  = sent_q && mem_rsp_valid;
    take_word = s_ready && s_valid;
    // full check against a freshly read index uses the whole word
    fresh_full = (mem_rsp_rdata == DATA_W'(tail_next));
  end

  always_comb begin
    state_n    = state_q;
    clr_ptrs   = 1'b0;
    head_load  = 1'b0;
    tail_adv   = 1'b0;
    timer_load = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_n  = ST_INIT_HEAD;
        clr_ptrs = 1'b1;
      end
      ST_INIT_HEAD: if (rsp_done) state_n = ST_INIT_TAIL;
      ST_INIT_TAIL: if (rsp_done) state_n = ST_INIT_CAP;
      ST_INIT_CAP:  if (rsp_done) state_n = ST_READY;
      ST_READY: if (take_word) state_n = ring_full ? ST_READ_HEAD : ST_WRITE_SLOT;
      ST_READ_HEAD: if (rsp_done) begin
        head_load = 1'b1;
        if (fresh_full) begin
          state_n    = ST_POLL_WAIT;
          timer_load = 1'b1;
        end else begin
          state_n = ST_WRITE_SLOT;
        end
      end
      ST_POLL_WAIT:  if (timer_exp) state_n = ST_READ_HEAD;
      ST_WRITE_SLOT: if (rsp_done) state_n = ST_WRITE_TAIL;
      ST_WRITE_TAIL: if (rsp_done) begin
        state_n  = ST_READY;
        tail_adv = 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase

    sent_n = sent_q;
    if (mem_req_valid && mem_req_ready) sent_n = 1'b1;
    else if (rsp_done)                  sent_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sent_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      sent_q  <= sent_n;
    end
  end

  always_ff @(posedge clk) begin
    if (take_word) data_q <= s_data;
  end

  // R9: a stalled request holds still
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
       && $stable(mem_req_wdata)));

  // R4: the write-index update starts only after a memory response
  p_tail_after_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_WRITE_TAIL) |-> $past(mem_rsp_valid));

  // R8: a taken start raises busy
  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start) |=> busy);

  // R10: no new word while a request is still in flight
  p_ready_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (!mem_req_valid && !sent_q));

endmodule

// File: tb/ringq_producer_tb.sv
module ringq_producer_tb;

  localparam int          CAP  = 8;
  localparam logic [31:0] BASE = 32'h1000;
  localparam int          LAT  = 3;
  localparam int          POLL = 12;
  localparam int          NSEQ = 64;
  localparam int          NTOT = 104;
  localparam int          MEMW = 4 + CAP;

  logic        clk = 1'b0;
  logic        rst_n, start, s_valid, s_ready;
  logic [15:0] poll_interval;
  logic [31:0] s_data;
  logic        mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid, busy;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rsp_rdata;

  always #5 clk = ~clk;

  ringq_producer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .poll_interval(poll_interval),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .busy(busy)
  );

  int checks = 0, errors = 0;
  logic [31:0] mem [MEMW];
  logic [31:0] exp_q[$];
  int  cyc = 0, acc_cnt = 0, consumed = 0, full_reads = 0;
  int  rsp_cnt = 0, setup_idx = 0, pend_words = 0, last_rsp_cyc = 0;
  bit  pend_rd = 0, pend_slot = 0, pend_tail = 0, slot_rsp_seen = 0;
  bit  last_rd_full = 0, prev_block = 0, consumer_en = 0, monitor_on = 0;
  logic [31:0] prev_addr = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] v);
    return (v + 1) % CAP;
  endfunction

  // memory, consumer and protocol monitor, all away from the active edge
  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = 1'b0;
    if (monitor_on) begin
      if (consumer_en && mem[0] != mem[1]) begin
        logic [31:0] v, e;
        v = mem[4 + mem[0]];
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hBAD0BAD0;
        chk(v == e, "R7", "drained word", v, e);
        mem[0] = nxt(mem[0]);
        consumed++;
      end
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          if (pend_rd) begin
            mem_rsp_rdata = mem[0];
            last_rd_full  = (nxt(mem[1]) == mem[0]);
            last_rsp_cyc  = cyc;
            if (last_rd_full) full_reads++;
          end
          if (pend_slot) slot_rsp_seen = 1'b1;
          if (pend_tail) pend_words--;
        end
      end
      if (prev_block)  // R9
        chk(mem_req_valid && mem_req_addr == prev_addr, "R9", "held request",
            mem_req_addr, prev_addr);
      if (s_valid && s_ready) begin
        chk(pend_words == 0, "R10", "word taken while previous open", pend_words, 0);
        exp_q.push_back(s_data);
        pend_words++;
        acc_cnt++;
      end
      mem_req_ready = ($urandom % 4) != 0;
      if (mem_req_valid && mem_req_ready) begin
        int idx;
        idx = int'((mem_req_addr - BASE) >> 2);
        chk(rsp_cnt == 0, "R9", "second outstanding request", rsp_cnt, 0);
        pend_rd = !mem_req_write; pend_slot = 1'b0; pend_tail = 1'b0;
        if (!mem_req_write) begin
          chk(mem_req_addr == BASE, "R6", "read address", mem_req_addr, BASE);
          if (last_rd_full)
            chk(cyc - last_rsp_cyc >= POLL + 1, "R6", "poll gap",
                cyc - last_rsp_cyc, POLL + 1);
          last_rd_full = 1'b0;
        end else if (setup_idx < 3) begin
          chk(mem_req_addr == BASE + 4 * setup_idx, "R2", "setup address",
              mem_req_addr, BASE + 4 * setup_idx);
          chk(mem_req_wdata == ((setup_idx == 2) ? CAP : 0), "R2", "setup data",
              mem_req_wdata, (setup_idx == 2) ? CAP : 0);
          mem[idx] = mem_req_wdata;
          setup_idx++;
        end else if (idx >= 4 && idx < MEMW) begin
          chk(idx - 4 == int'(mem[1]), "R3", "slot index", idx - 4, mem[1]);
          mem[idx] = mem_req_wdata;
          pend_slot = 1'b1;
          slot_rsp_seen = 1'b0;
        end else if (idx == 1) begin
          chk(slot_rsp_seen, "R4", "index update before slot ack", 0, 1);
          chk(mem_req_wdata == nxt(mem[1]), "R4", "index value",
              mem_req_wdata, nxt(mem[1]));
          chk(mem_req_wdata != mem[0], "R5", "overrun of read index",
              mem_req_wdata, mem[0]);
          mem[1] = mem_req_wdata;
          slot_rsp_seen = 1'b0;
          pend_tail = 1'b1;
        end else begin
          chk(1'b0, "R3", "stray write address", mem_req_addr, BASE);
        end
        rsp_cnt = LAT;
      end
      prev_block = mem_req_valid && !mem_req_ready;
      prev_addr  = mem_req_addr;
    end
  end

  // consumer pacing: held off first, then random with pauses
  initial begin
    wait (monitor_on && setup_idx == 3);
    repeat (400) @(posedge clk);
    forever begin
      @(posedge clk); #1;
      if (consumed + 8 >= NTOT || acc_cnt >= NTOT) consumer_en = 1'b1;
      else consumer_en = (cyc % 300 < 200) ? (($urandom % 3) != 0) : 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", consumed, NTOT);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit quiet;
    void'($urandom(32'd4711));
    for (int k = 0; k < MEMW; k++) mem[k] = '0;
    rst_n = 1'b0; start = 1'b0; s_valid = 1'b0; s_data = '0;
    poll_interval = 16'(POLL); mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
    mem_rsp_rdata = '0;
    repeat (3) @(negedge clk);
    chk(!s_ready, "R1", "s_ready in reset", s_ready, 0);
    chk(!mem_req_valid, "R1", "mem_req_valid in reset", mem_req_valid, 0);
    chk(!busy, "R1", "busy in reset", busy, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    monitor_on = 1'b1;
    // R1: input offered before setup is ignored
    s_valid = 1'b1; s_data = 32'hDEAD_BEEF;
    quiet = 1'b1;
    repeat (8) begin
      @(negedge clk);
      if (s_ready || mem_req_valid || busy) quiet = 1'b0;
    end
    chk(quiet && acc_cnt == 0, "R1", "activity before start", acc_cnt, 0);
    @(posedge clk); #1 s_valid = 1'b0; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    chk(busy, "R8", "busy after start", busy, 1);
    wait (s_ready);
    chk(setup_idx == 3, "R2", "setup writes done", setup_idx, 3);
    for (int i = 0; i < NTOT; i++) begin
      @(posedge clk); #1;
      if (i >= NSEQ && ($urandom % 3) == 0) begin
        s_valid = 1'b0;
        repeat ($urandom % 5) @(posedge clk);
        #1;
      end
      s_valid = 1'b1;
      s_data  = (i < NSEQ) ? 32'(i) : $urandom;
      while (acc_cnt <= i) begin
        @(posedge clk); #1;
      end
      s_valid = 1'b0;
    end
    wait (consumed == NTOT);
    repeat (10) @(negedge clk);
    chk(!busy, "R8", "busy when drained", busy, 0);
    chk(s_ready, "R10", "ready when idle", s_ready, 1);
    chk(exp_q.size() == 0, "R7", "words left undrained", exp_q.size(), 0);
    chk(consumed == NTOT, "R7", "word count", consumed, NTOT);
    chk(full_reads > 0, "R6", "full ring polled", full_reads, 1);
    chk(mem[1] == NTOT % CAP, "R4", "final write index", mem[1], NTOT % CAP);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule